// File: doc/BRIEF.md
# Indirect Memory Access Window

This block gives a host on a simple 32-bit register interface indirect access to two device-internal resources. It reaches a word memory through a read pointer and a write pointer. It reaches peripheral registers through a second pair of pointers whose value also carries a transfer size. The host loads a pointer register first. It then accesses the data register that belongs to that pointer. Each memory data access moves its own pointer on by one dword, and the read side and write side move independently. Peripheral pointers stay where they were loaded.

On its internal side the block is a master with two ports. The first is an SRAM port with a one-cycle read latency. The second is a peripheral register port with per-byte write enables. A single enable input stands in for the wake handshake that makes the internal side reachable. When it is low, data-register accesses do nothing internally: reads return a fixed filler pattern and no pointer moves. Pointer loads still take effect while the enable is low.

Every bus access completes in one cycle. Read data is returned on the cycle after the request, together with a valid strobe.

Top module: `ind_mem_window`

## Requirements
- R1: A bus write to register index 3 (memory write data) issues one SRAM write in the same cycle, at the current write pointer, carrying the bus data. At most one internal strobe is active in any cycle.
- R2: Each memory data write advances the write pointer by 4 (one dword), so the next write lands on the following word.
- R3: A bus read of register index 1 (memory read data) returns, with `rvalid_o` in the next cycle, the word at the read pointer as it stood when the read was issued. The read pointer then advances by 4.
- R4: Writing index 0 loads the read pointer and writing index 2 loads the write pointer, using all 32 bits as a byte address. Reads of these indices return the pointers, and loading or advancing one pointer leaves the other unchanged.
- R5: Index 6 is the peripheral write pointer and index 7 its data register. A write to index 7 drives the register offset from pointer bits 15:0 and sets the byte enables for bytes 0 to N, where N is taken from pointer bits 25:24. The pointer does not advance.
- R6: Index 4 is the peripheral read pointer and index 5 its data register. A read of index 5 returns the register at the pointer's offset, with bytes above N forced to zero. Repeated reads hit the same offset.
- R7: While `en_i` is low, data writes produce no internal write, data reads return 0xA5A5A5A5, and neither pointer moves.
- R8: After reset all four pointers read as zero and no strobe or `rvalid_o` is active.
- R9: A read of a peripheral pointer returns the offset in bits 15:0 and the byte count in bits 25:24, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Internal side reachable; gates data-register accesses |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | Bus write when high, read when low |
| reg_sel_i | input | 3 | Register index within the window |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe, one cycle after a read request |
| sram_re_o | output | 1 | SRAM read strobe |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_addr_o | output | 32 | SRAM byte address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, one cycle after sram_re_o |
| per_re_o | output | 1 | Peripheral read strobe |
| per_we_o | output | 1 | Peripheral write strobe |
| per_addr_o | output | 16 | Peripheral register offset |
| per_be_o | output | 4 | Peripheral byte write enables |
| per_wdata_o | output | 32 | Peripheral write data |
| per_rdata_i | input | 32 | Peripheral read data, one cycle after per_re_o |

## Verification
The properties assume that the bus issues at most one request per cycle. They also assume that `req_i`, `we_i`, `reg_sel_i` and `en_i` are stable across each sampling edge, and that the internal responders return data exactly one cycle after a read strobe. The bench drives every input on the falling clock edge and holds it for one full cycle. Its SRAM and peripheral models register read data on the rising edge after the strobe, so each of these conditions is met by construction of the stimulus.

// File: rtl/ind_win_pkg.sv
package ind_win_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    WIN_MEM_RPTR = 3'd0,
    WIN_MEM_RDAT = 3'd1,
    WIN_MEM_WPTR = 3'd2,
    WIN_MEM_WDAT = 3'd3,
    WIN_PER_RPTR = 3'd4,
    WIN_PER_RDAT = 3'd5,
    WIN_PER_WPTR = 3'd6,
    WIN_PER_WDAT = 3'd7
  } win_reg_e;

  typedef enum logic [1:0] {
    RSP_REG   = 2'd0,
    RSP_SRAM  = 2'd1,
    RSP_PER   = 2'd2,
    RSP_BLOCK = 2'd3
  } rsp_src_e;

  localparam logic [7:0] BLOCK_BYTE = 8'hA5;
endpackage

// File: rtl/ind_win_mem_ptr.sv
module ind_win_mem_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (load_i)  ptr_o <= load_val_i;
    else if (step_i)  ptr_o <= ptr_o + STEP_V;
  end
endmodule

// File: rtl/ind_win_per_ptr.sv
module ind_win_per_ptr #(
  parameter int OFS_W = 16,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o <= '0;
      cnt_o <= '0;
    end else if (load_i) begin
      ofs_o <= ofs_i;
      cnt_o <= cnt_i;
    end
  end
endmodule

// File: rtl/ind_win_lane.sv
module ind_win_lane #(
  parameter int LANES = 4,
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [LANES-1:0]   be_o,
  output logic [LANES*8-1:0] mask_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[i]         = (int'(cnt_i) >= i);
    assign mask_o[8*i +: 8] = {8{be_o[i]}};
  end
endmodule

// File: rtl/ind_win_rsp.sv
module ind_win_rsp
  import ind_win_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  rsp_src_e      src_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] sram_rdata_i,
  input  logic [DW-1:0] per_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam logic [DW-1:0] BLOCK_PAT = {(DW/8){BLOCK_BYTE}};

  rsp_src_e      src_q;
  logic [DW-1:0] reg_q;
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      src_q    <= RSP_REG;
      reg_q    <= '0;
      mask_q   <= '0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) begin
        src_q  <= src_i;
        reg_q  <= reg_val_i;
        mask_q <= mask_i;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      RSP_SRAM:  rdata_o = sram_rdata_i;
      RSP_PER:   rdata_o = per_rdata_i & mask_q;
      RSP_BLOCK: rdata_o = BLOCK_PAT;
      default:   rdata_o = reg_q;
    endcase
  end
endmodule

// File: rtl/ind_mem_window.sv
module ind_mem_window
  import ind_win_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int MEM_AW      = 32,
  parameter int PER_OFS_W   = 16,
  parameter int PER_CNT_LSB = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [REG_IDX_W-1:0]   reg_sel_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o,
  output logic                   sram_re_o,
  output logic                   sram_we_o,
  output logic [MEM_AW-1:0]      sram_addr_o,
  output logic [DATA_W-1:0]      sram_wdata_o,
  input  logic [DATA_W-1:0]      sram_rdata_i,
  output logic                   per_re_o,
  output logic                   per_we_o,
  output logic [PER_OFS_W-1:0]   per_addr_o,
  output logic [DATA_W/8-1:0]    per_be_o,
  output logic [DATA_W-1:0]      per_wdata_o,
  input  logic [DATA_W-1:0]      per_rdata_i
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES);
  localparam int STEP  = DATA_W / 8;

  win_reg_e sel;
  logic     bus_wr, bus_rd;
  assign sel    = win_reg_e'(reg_sel_i);
  assign bus_wr = req_i & we_i;
  assign bus_rd = req_i & ~we_i;

  // pointers
  logic [MEM_AW-1:0]    mem_rptr, mem_wptr;
  logic [PER_OFS_W-1:0] per_rofs, per_wofs;
  logic [CNT_W-1:0]     per_rcnt, per_wcnt;

  ind_win_mem_ptr #(.AW(MEM_AW), .STEP(STEP)) u_mem_rptr (
    .clk_i, .rst_ni,
    .load_i     (bus_wr && sel == WIN_MEM_RPTR),
    .load_val_i (wdata_i[MEM_AW-1:0]),
    .step_i     (sram_re_o),
    .ptr_o      (mem_rptr)
  );

  ind_win_mem_ptr #(.AW(MEM_AW), .STEP(STEP)) u_mem_wptr (
    .clk_i, .rst_ni,
    .load_i     (bus_wr && sel == WIN_MEM_WPTR),
    .load_val_i (wdata_i[MEM_AW-1:0]),
    .step_i     (sram_we_o),
    .ptr_o      (mem_wptr)
  );

  ind_win_per_ptr #(.OFS_W(PER_OFS_W), .CNT_W(CNT_W)) u_per_rptr (
    .clk_i, .rst_ni,
    .load_i (bus_wr && sel == WIN_PER_RPTR),
    .ofs_i  (wdata_i[PER_OFS_W-1:0]),
    .cnt_i  (wdata_i[PER_CNT_LSB +: CNT_W]),
    .ofs_o  (per_rofs),
    .cnt_o  (per_rcnt)
  );

  ind_win_per_ptr #(.OFS_W(PER_OFS_W), .CNT_W(CNT_W)) u_per_wptr (
    .clk_i, .rst_ni,
    .load_i (bus_wr && sel == WIN_PER_WPTR),
    .ofs_i  (wdata_i[PER_OFS_W-1:0]),
    .cnt_i  (wdata_i[PER_CNT_LSB +: CNT_W]),
    .ofs_o  (per_wofs),
    .cnt_o  (per_wcnt)
  );

  // byte lanes
  logic [LANES-1:0]  wr_be, rd_be;
  logic [DATA_W-1:0] wr_mask, rd_mask;

  ind_win_lane #(.LANES(LANES), .CNT_W(CNT_W)) u_wr_lane (
    .cnt_i (per_wcnt), .be_o (wr_be), .mask_o (wr_mask)
  );

  ind_win_lane #(.LANES(LANES), .CNT_W(CNT_W)) u_rd_lane (
    .cnt_i (per_rcnt), .be_o (rd_be), .mask_o (rd_mask)
  );

  // internal strobes, gated by enable
  assign sram_we_o    = en_i & bus_wr & (sel == WIN_MEM_WDAT);
  assign sram_re_o    = en_i & bus_rd & (sel == WIN_MEM_RDAT);
  assign sram_addr_o  = sram_we_o ? mem_wptr : mem_rptr;
  assign sram_wdata_o = wdata_i;

  assign per_we_o     = en_i & bus_wr & (sel == WIN_PER_WDAT);
  assign per_re_o     = en_i & bus_rd & (sel == WIN_PER_RDAT);
  assign per_addr_o   = per_we_o ? per_wofs : per_rofs;
  assign per_be_o     = wr_be;
  assign per_wdata_o  = wdata_i & wr_mask;

  // readback of pointer registers
  logic [DATA_W-1:0] per_rptr_word, per_wptr_word, reg_val;
  rsp_src_e          src;

  always_comb begin
    per_rptr_word = '0;
    per_rptr_word[PER_OFS_W-1:0]        = per_rofs;
    per_rptr_word[PER_CNT_LSB +: CNT_W] = per_rcnt;
    per_wptr_word = '0;
    per_wptr_word[PER_OFS_W-1:0]        = per_wofs;
    per_wptr_word[PER_CNT_LSB +: CNT_W] = per_wcnt;
  end

  always_comb begin
    reg_val = '0;
    src     = RSP_REG;
    unique case (sel)
      WIN_MEM_RPTR: reg_val = DATA_W'(mem_rptr);
      WIN_MEM_WPTR: reg_val = DATA_W'(mem_wptr);
      WIN_PER_RPTR: reg_val = per_rptr_word;
      WIN_PER_WPTR: reg_val = per_wptr_word;
      WIN_MEM_RDAT: src = en_i ? RSP_SRAM : RSP_BLOCK;
      WIN_PER_RDAT: src = en_i ? RSP_PER  : RSP_BLOCK;
      default:      reg_val = '0;
    endcase
  end

  ind_win_rsp #(.DW(DATA_W)) u_rsp (
    .clk_i, .rst_ni,
    .capture_i    (bus_rd),
    .src_i        (src),
    .reg_val_i    (reg_val),
    .mask_i       (rd_mask),
    .sram_rdata_i (sram_rdata_i),
    .per_rdata_i  (per_rdata_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o)
  );

  logic unused_rd_be;
  assign unused_rd_be = ^rd_be;
endmodule

// File: rtl/ind_mem_window_chk.sv
module ind_mem_window_chk #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                req_i,
  input logic                we_i,
  input logic [2:0]          reg_sel_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                rvalid_o,
  input logic                sram_re_o,
  input logic                sram_we_o,
  input logic [MEM_AW-1:0]   sram_addr_o,
  input logic                per_re_o,
  input logic                per_we_o,
  input logic [DATA_W/8-1:0] per_be_o
);
  localparam logic [MEM_AW-1:0] STEP_V = MEM_AW'(DATA_W / 8);
  localparam logic [DATA_W-1:0] BLOCK_PAT = {(DATA_W/8){8'hA5}};

  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sram_re_o, sram_we_o, per_re_o, per_we_o}));

  assert_wptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |=> (!sram_we_o || sram_addr_o == $past(sram_addr_o) + STEP_V));

  assert_rptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_re_o |=> (!sram_re_o || sram_addr_o == $past(sram_addr_o) + STEP_V));

  assert_resp_next_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_no_spurious_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  assert_be_contiguous_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_we_o |-> (per_be_o[0] && ((per_be_o & (per_be_o + 1'b1)) == '0)));

  assert_gate_writes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_o || per_we_o || sram_re_o || per_re_o) |-> en_i);

  assert_block_pattern_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !en_i && (reg_sel_i == 3'd1 || reg_sel_i == 3'd5))
      |=> (rdata_o == BLOCK_PAT));
endmodule

bind ind_mem_window ind_mem_window_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .reg_sel_i   (reg_sel_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .sram_re_o   (sram_re_o),
  .sram_we_o   (sram_we_o),
  .sram_addr_o (sram_addr_o),
  .per_re_o    (per_re_o),
  .per_we_o    (per_we_o),
  .per_be_o    (per_be_o)
);

// File: tb/sim_ind_mem_window.sv
module sim_ind_mem_window;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        sram_re, sram_we, per_re, per_we;
  logic [31:0] sram_addr, sram_wdata, per_wdata;
  logic [31:0] sram_rdata, per_rdata;
  logic [15:0] per_addr;
  logic [3:0]  per_be;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_mem_window u0 (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en),
    .req_i (req), .we_i (we), .reg_sel_i (sel), .wdata_i (wdata),
    .rdata_o (rdata), .rvalid_o (rvalid),
    .sram_re_o (sram_re), .sram_we_o (sram_we), .sram_addr_o (sram_addr),
    .sram_wdata_o (sram_wdata), .sram_rdata_i (sram_rdata),
    .per_re_o (per_re), .per_we_o (per_we), .per_addr_o (per_addr),
    .per_be_o (per_be), .per_wdata_o (per_wdata), .per_rdata_i (per_rdata)
  );

  // behavioural SRAM, 64 words, one-cycle read
  logic [31:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | i;
  always @(posedge clk) begin
    if (sram_we) mem[sram_addr[7:2]] <= sram_wdata;
    if (sram_re) sram_rdata <= mem[sram_addr[7:2]];
  end

  // behavioural peripheral register file with byte enables
  logic [31:0] prf [16];
  initial for (int i = 0; i < 16; i++) prf[i] = '0;
  always @(posedge clk) begin
    if (per_we)
      for (int b = 0; b < 4; b++)
        if (per_be[b]) prf[per_addr[5:2]][8*b +: 8] <= per_wdata[8*b +: 8];
    if (per_re) per_rdata <= prf[per_addr[5:2]];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] s, input logic [31:0] d);
    req = 1'b1; we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; sel = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected response", rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rvalid && !sram_we && !sram_re && !per_we && !per_re, "R8 idle after reset",
          {27'b0, rvalid, sram_we, sram_re, per_we, per_re}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rvalid && !sram_we && !per_we, "R8 idle out of reset",
          {29'b0, rvalid, sram_we, per_we}, 32'h0);

    bus_rd(3'd0, 32'h0, "R8 mem read ptr reset");
    bus_rd(3'd2, 32'h0, "R8 mem write ptr reset");
    bus_rd(3'd4, 32'h0, "R8 per read ptr reset");

    // R3: sequential reads
    bus_wr(3'd0, 32'h10);
    bus_rd(3'd1, 32'hC0DE_0004, "R3 read word 4");
    bus_rd(3'd1, 32'hC0DE_0005, "R3 read word 5");
    bus_rd(3'd1, 32'hC0DE_0006, "R3 read word 6");
    bus_rd(3'd0, 32'h1C, "R3 read ptr advanced");

    // R1/R2/R4: writes
    bus_wr(3'd2, 32'h20);
    bus_wr(3'd3, 32'hAAAA_0001);
    bus_wr(3'd3, 32'hAAAA_0002);
    bus_rd(3'd2, 32'h28, "R2 write ptr advanced");
    bus_rd(3'd0, 32'h1C, "R4 read ptr independent");
    bus_wr(3'd0, 32'h20);
    bus_rd(3'd1, 32'hAAAA_0001, "R1 written word 8");
    bus_rd(3'd1, 32'hAAAA_0002, "R1 written word 9");
    bus_rd(3'd1, 32'hC0DE_000A, "R1 word 10 untouched");
    bus_rd(3'd2, 32'h28, "R4 write ptr independent");

    // R7: gated accesses
    en = 1'b0;
    bus_wr(3'd3, 32'hDEAD_BEEF);
    bus_rd(3'd1, 32'hA5A5_A5A5, "R7 blocked mem read");
    bus_rd(3'd2, 32'h28, "R7 write ptr held");
    bus_rd(3'd0, 32'h2C, "R7 read ptr held");
    bus_wr(3'd0, 32'h28);
    en = 1'b1;
    bus_rd(3'd1, 32'hC0DE_000A, "R7 blocked write ignored");

    // R5/R9: peripheral writes
    bus_wr(3'd6, 32'h0300_0008);
    bus_rd(3'd6, 32'h0300_0008, "R9 per write ptr format");
    bus_wr(3'd7, 32'h1122_3344);
    bus_wr(3'd4, 32'hFF03_0008);
    bus_rd(3'd4, 32'h0300_0008, "R9 per read ptr drops other bits");
    bus_rd(3'd5, 32'h1122_3344, "R5 full dword write");
    bus_rd(3'd5, 32'h1122_3344, "R6 no auto-increment");
    bus_wr(3'd6, 32'h0000_0008);
    bus_wr(3'd7, 32'hAABB_CCDD);
    bus_rd(3'd5, 32'h1122_33DD, "R5 one-byte write");
    bus_wr(3'd6, 32'h0100_0008);
    bus_wr(3'd7, 32'hFFFF_EEFF);
    bus_rd(3'd5, 32'h1122_EEFF, "R5 two-byte write");

    // R6: short reads
    bus_wr(3'd4, 32'h0100_0008);
    bus_rd(3'd5, 32'h0000_EEFF, "R6 two-byte read");
    bus_wr(3'd4, 32'h0200_0008);
    bus_rd(3'd5, 32'h0022_EEFF, "R6 three-byte read");
    bus_wr(3'd4, 32'h0000_0008);
    bus_rd(3'd5, 32'h0000_00FF, "R6 one-byte read");

    // R7: gated peripheral
    en = 1'b0;
    bus_wr(3'd6, 32'h0300_0008);
    bus_wr(3'd7, 32'h0BAD_0BAD);
    bus_rd(3'd5, 32'hA5A5_A5A5, "R7 blocked per read");
    en = 1'b1;
    bus_wr(3'd4, 32'h0300_0008);
    bus_rd(3'd5, 32'h1122_EEFF, "R7 blocked per write ignored");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all responses seen", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule